// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns 32-bit linear addresses into physical addresses. It walks a two-level table held in memory, starting from a root register that holds the physical address of the directory page. Each page is 4096 bytes. The top ten address bits pick a directory entry. That entry names a second-level table. The next ten bits pick a table entry, which names the physical frame. The low twelve bits pass through as the byte offset.

A small fully associative translation cache keeps recent results, so repeated accesses to the same page skip both memory reads. Every access, cached or walked, is checked against three bits: present, writable and user. A failed check returns a fault code and the faulting linear address instead of a physical address. When paging is disabled, the linear address comes back unchanged. A write to the root register installs a new directory and invalidates every cached translation.

The control is one state machine. Its states are:
- `ST_IDLE`: ready for a request.
- `ST_LOOKUP`: cache probe.
- `ST_DIR_REQ`, then `ST_DIR_WAIT`: directory read issued, then awaited.
- `ST_TBL_REQ`, then `ST_TBL_WAIT`: table read issued, then awaited.
- `ST_RESP`: one-cycle response.

Its transitions are:
- `ST_IDLE` goes to `ST_LOOKUP` when a request is accepted with paging enabled, or straight to `ST_RESP` when paging is disabled.
- `ST_LOOKUP` goes to `ST_RESP` on a hit and to `ST_DIR_REQ` on a miss.
- `ST_DIR_REQ` always goes to `ST_DIR_WAIT`.
- `ST_DIR_WAIT` goes to `ST_TBL_REQ` when the returned directory entry is present, and to `ST_RESP` when it is absent.
- `ST_TBL_REQ` always goes to `ST_TBL_WAIT`.
- `ST_TBL_WAIT` goes to `ST_RESP` when the table entry returns.
- `ST_RESP` always returns to `ST_IDLE`.

Top module: `pt_walker`

## Requirements
- R1: After reset `req_ready` is 1, `rsp_valid` is 0, `mem_rd_en` is 0, the root register is 0 and the cache holds no valid entry.
- R2: A request accepted while `paging_en` is 0 responds one cycle after acceptance. It returns `rsp_paddr` equal to the linear address with no fault, and it issues no memory read.
- R3: Linear address bits [31:22] index the directory, bits [21:12] index the table, and bits [11:0] are the offset. The directory read address is {root[31:12], la[31:22], 2'b00}. The table read address is {dir_entry[31:12], la[21:12], 2'b00}. A successful result is {tbl_entry[31:12], la[11:0]}. In every entry, bit 0 is present, bit 1 is writable, bit 2 is user, and bits [31:12] are the frame.
- R4: If the present bit is 0 at either level, the fault code is 1 (absent). An absent directory entry ends the walk after one memory read.
- R5: If the access is a user access and the user permission is 0, the fault code is 3. The user permission is the AND of the user bits of both levels. This check takes priority over the write check.
- R6: If the access is a write and the write permission is 0, the fault code is 2. The write permission is the AND of the writable bits of both levels. This applies in either privilege mode.
- R7: When a fault occurs, `rsp_fault` is 1, `rsp_fault_code` is nonzero, `rsp_fault_addr` equals the linear address and `rsp_paddr` is 0. On success, `rsp_fault` is 0 and the code is 0.
- R8: A walk that finds both levels present fills a cache entry with the combined permissions. A later request to the same page issues no memory read, responds two cycles after acceptance, and is checked against the cached permissions.
- R9: The cache holds 4 entries and replaces them round-robin. After a flush and five distinct fills, the first page filled misses again and the other four still hit.
- R10: A write on the root-register port loads the new root and invalidates all cached translations. The next request to a previously cached page walks again through the new root.
- R11: `req_ready` is 1 only in `ST_IDLE`. Only one request is in flight at a time, and `rsp_valid` is a one-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| paging_en | input | 1 | Translation enable, sampled when a request is accepted |
| base_wr_en | input | 1 | Root-register write strobe |
| base_wr_data | input | 32 | New root value (bits [31:12] kept) |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 32 | Linear address |
| req_write | input | 1 | Access is a write |
| req_user | input | 1 | Access is made in user mode |
| rsp_valid | output | 1 | Response pulse |
| rsp_paddr | output | 32 | Physical address (0 on fault) |
| rsp_fault | output | 1 | Page fault indicator |
| rsp_fault_code | output | 2 | 0 none, 1 absent, 2 write, 3 user |
| rsp_fault_addr | output | 32 | Linear address of the response |
| mem_rd_en | output | 1 | Memory read request (one-cycle pulse) |
| mem_rd_addr | output | 32 | Memory read word address (byte address, word aligned) |
| mem_rd_valid | input | 1 | Read data valid (one-cycle pulse) |
| mem_rd_data | input | 32 | Read data word |

## Verification
The assertions assume three things about the inputs:
- The memory answers each read with exactly one `mem_rd_valid` pulse, and only while a read is outstanding.
- No spurious read data arrives in other states.
- Each fill targets a page not already in the cache, which is what keeps cache hits one-hot.

The bench meets these with a memory model that returns every read one cycle after the strobe. It presents a new request only after `req_ready` is seen. It writes the root register only while the block is idle. It visits each page in a fresh order, so no duplicate fill can arise.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    localparam int LA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int IDX_W  = 10;
    localparam int VPN_W  = LA_W - OFF_W;
    localparam int PFN_W  = LA_W - OFF_W;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_DIR_REQ,
        ST_DIR_WAIT,
        ST_TBL_REQ,
        ST_TBL_WAIT,
        ST_RESP
    } walk_state_e;

    typedef enum logic [1:0] {
        FLT_NONE   = 2'd0,
        FLT_ABSENT = 2'd1,
        FLT_WRITE  = 2'd2,
        FLT_USER   = 2'd3
    } fault_code_e;

    typedef struct packed {
        logic [PFN_W-1:0] frame;
        logic [8:0]       spare;
        logic             usr;
        logic             wr;
        logic             pres;
    } table_entry_t;

endpackage

// File: rtl/pt_perm_check.sv
module pt_perm_check
    import pt_walker_pkg::*;
(
    input  logic        present,
    input  logic        wr_ok,
    input  logic        usr_ok,
    input  logic        is_write,
    input  logic        is_user,
    output fault_code_e code
);

    always_comb begin
        if (!present) begin
            code = FLT_ABSENT;
        end else if (is_user && !usr_ok) begin
            code = FLT_USER;
        end else if (is_write && !wr_ok) begin
            code = FLT_WRITE;
        end else begin
            code = FLT_NONE;
        end
    end

endmodule

// File: rtl/pt_tlb.sv
module pt_tlb #(
    parameter int ENTRIES = 4,
    parameter int VPN_W   = 20,
    parameter int PFN_W   = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [VPN_W-1:0] lk_vpn,
    output logic             hit,
    output logic [PFN_W-1:0] hit_pfn,
    output logic             hit_wr,
    output logic             hit_usr,
    input  logic             fill_en,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [PFN_W-1:0] fill_pfn,
    input  logic             fill_wr,
    input  logic             fill_usr
);

    localparam int PTR_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;
    localparam logic [PTR_W-1:0] LAST = PTR_W'(ENTRIES - 1);

    logic [ENTRIES-1:0]   valid_q;
    logic [VPN_W-1:0]     vpn_q [ENTRIES];
    logic [PFN_W-1:0]     pfn_q [ENTRIES];
    logic [ENTRIES-1:0]   wr_q;
    logic [ENTRIES-1:0]   usr_q;
    logic [PTR_W-1:0]     ptr_q;
    logic [ENTRIES-1:0]   match;

    for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
        assign match[g] = valid_q[g] && (vpn_q[g] == lk_vpn);

        always_ff @(posedge clk) begin
            if (!rst_n || flush) begin
                valid_q[g] <= 1'b0;
            end else if (fill_en && ptr_q == PTR_W'(g)) begin
                valid_q[g] <= 1'b1;
                vpn_q[g]   <= fill_vpn;
                pfn_q[g]   <= fill_pfn;
                wr_q[g]    <= fill_wr;
                usr_q[g]   <= fill_usr;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ptr_q <= '0;
        end else if (fill_en) begin
            ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
        end
    end

    always_comb begin
        hit     = |match;
        hit_pfn = '0;
        hit_wr  = 1'b0;
        hit_usr = 1'b0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (match[i]) begin
                hit_pfn = hit_pfn | pfn_q[i];
                hit_wr  = hit_wr  | wr_q[i];
                hit_usr = hit_usr | usr_q[i];
            end
        end
    end

    // R8
    match_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(match));

    // R10
    flush_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> !hit);

endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int TLB_ENTRIES = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        paging_en,
    input  logic        base_wr_en,
    input  logic [31:0] base_wr_data,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_user,
    output logic        rsp_valid,
    output logic [31:0] rsp_paddr,
    output logic        rsp_fault,
    output logic [1:0]  rsp_fault_code,
    output logic [31:0] rsp_fault_addr,
    output logic        mem_rd_en,
    output logic [31:0] mem_rd_addr,
    input  logic        mem_rd_valid,
    input  logic [31:0] mem_rd_data
);

    walk_state_e      state_q, state_d;
    logic [LA_W-1:0]  la_q;
    logic             wr_q, usr_q;
    logic [PFN_W-1:0] root_q;
    logic             stale_q;
    logic [PFN_W-1:0] pde_frame_q;
    logic             pde_wr_q, pde_usr_q;
    logic [LA_W-1:0]  res_paddr_q;
    fault_code_e      res_code_q;

    logic             accept;
    table_entry_t     rd_entry;
    logic             hit_raw, hit_use;
    logic [PFN_W-1:0] hit_pfn;
    logic             hit_wr, hit_usr;
    logic             chk_p, chk_w, chk_u;
    fault_code_e      chk_code;
    logic             fill_en;
    logic [PFN_W-1:0] res_frame;

    assign accept   = req_valid && req_ready;
    assign rd_entry = table_entry_t'(mem_rd_data);
    assign hit_use  = hit_raw && !stale_q && !base_wr_en;

    pt_tlb #(
        .ENTRIES (TLB_ENTRIES),
        .VPN_W   (VPN_W),
        .PFN_W   (PFN_W)
    ) u_tlb (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush    (base_wr_en),
        .lk_vpn   (la_q[LA_W-1:OFF_W]),
        .hit      (hit_raw),
        .hit_pfn  (hit_pfn),
        .hit_wr   (hit_wr),
        .hit_usr  (hit_usr),
        .fill_en  (fill_en),
        .fill_vpn (la_q[LA_W-1:OFF_W]),
        .fill_pfn (rd_entry.frame),
        .fill_wr  (pde_wr_q & rd_entry.wr),
        .fill_usr (pde_usr_q & rd_entry.usr)
    );

    // permission inputs depend on which level is being judged
    always_comb begin
        chk_p     = 1'b1;
        chk_w     = 1'b1;
        chk_u     = 1'b1;
        res_frame = rd_entry.frame;
        if (state_q == ST_LOOKUP) begin
            chk_w     = hit_wr;
            chk_u     = hit_usr;
            res_frame = hit_pfn;
        end else if (state_q == ST_DIR_WAIT) begin
            chk_p = rd_entry.pres;
        end else if (state_q == ST_TBL_WAIT) begin
            chk_p = rd_entry.pres;
            chk_w = pde_wr_q & rd_entry.wr;
            chk_u = pde_usr_q & rd_entry.usr;
        end
    end

    pt_perm_check u_perm (
        .present  (chk_p),
        .wr_ok    (chk_w),
        .usr_ok   (chk_u),
        .is_write (wr_q),
        .is_user  (usr_q),
        .code     (chk_code)
    );

    assign fill_en = (state_q == ST_TBL_WAIT) && mem_rd_valid && rd_entry.pres
                     && !stale_q && !base_wr_en;

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (accept) begin
                    state_d = paging_en ? ST_LOOKUP : ST_RESP;
                end
            end
            ST_LOOKUP:   state_d = hit_use ? ST_RESP : ST_DIR_REQ;
            ST_DIR_REQ:  state_d = ST_DIR_WAIT;
            ST_DIR_WAIT: begin
                if (mem_rd_valid) begin
                    state_d = rd_entry.pres ? ST_TBL_REQ : ST_RESP;
                end
            end
            ST_TBL_REQ:  state_d = ST_TBL_WAIT;
            ST_TBL_WAIT: begin
                if (mem_rd_valid) begin
                    state_d = ST_RESP;
                end
            end
            ST_RESP:     state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        req_ready   = 1'b0;
        rsp_valid   = 1'b0;
        mem_rd_en   = 1'b0;
        mem_rd_addr = '0;
        unique case (state_q)
            ST_IDLE:     req_ready = 1'b1;
            ST_DIR_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = {root_q, la_q[LA_W-1:LA_W-IDX_W], 2'b00};
            end
            ST_TBL_REQ: begin
                mem_rd_en   = 1'b1;
                mem_rd_addr = {pde_frame_q, la_q[OFF_W+IDX_W-1:OFF_W], 2'b00};
            end
            ST_RESP:     rsp_valid = 1'b1;
            ST_LOOKUP, ST_DIR_WAIT, ST_TBL_WAIT: ;
        endcase
    end

    assign rsp_paddr      = res_paddr_q;
    assign rsp_fault_code = res_code_q;
    assign rsp_fault      = (res_code_q != FLT_NONE);
    assign rsp_fault_addr = la_q;

    // root register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            root_q <= '0;
        end else if (base_wr_en) begin
            root_q <= base_wr_data[LA_W-1:OFF_W];
        end
    end

    // request capture, walk context and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            la_q        <= '0;
            wr_q        <= 1'b0;
            usr_q       <= 1'b0;
            stale_q     <= 1'b0;
            pde_frame_q <= '0;
            pde_wr_q    <= 1'b0;
            pde_usr_q   <= 1'b0;
            res_paddr_q <= '0;
            res_code_q  <= FLT_NONE;
        end else begin
            if (accept) begin
                la_q    <= req_addr;
                wr_q    <= req_write;
                usr_q   <= req_user;
                stale_q <= 1'b0;
                if (!paging_en) begin
                    res_paddr_q <= req_addr;
                    res_code_q  <= FLT_NONE;
                end
            end else if (base_wr_en && state_q != ST_IDLE) begin
                stale_q <= 1'b1;
            end

            if (state_q == ST_LOOKUP && hit_use) begin
                res_code_q  <= chk_code;
                res_paddr_q <= (chk_code == FLT_NONE) ? {res_frame, la_q[OFF_W-1:0]} : '0;
            end

            if (state_q == ST_DIR_WAIT && mem_rd_valid) begin
                pde_frame_q <= rd_entry.frame;
                pde_wr_q    <= rd_entry.wr;
                pde_usr_q   <= rd_entry.usr;
                if (!rd_entry.pres) begin
                    res_code_q  <= chk_code;
                    res_paddr_q <= '0;
                end
            end

            if (state_q == ST_TBL_WAIT && mem_rd_valid) begin
                res_code_q  <= chk_code;
                res_paddr_q <= (chk_code == FLT_NONE) ? {res_frame, la_q[OFF_W-1:0]} : '0;
            end
        end
    end

    // R11
    rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R11
    accept_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R3
    rd_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    // R7
    fault_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_paddr == '0 && rsp_fault_code != 2'd0));

    // R2
    passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && !paging_en)
        |=> (rsp_valid && !rsp_fault && rsp_paddr == $past(req_addr)));

    // R4
    absent_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIR_WAIT && mem_rd_valid && !mem_rd_data[0])
        |=> (rsp_valid && rsp_fault_code == 2'd1));

endmodule

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        paging_en = 1'b0;
    logic        base_wr_en = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic [1:0]  rsp_fault_code;
    logic [31:0] rsp_fault_addr;
    logic        mem_rd_en;
    logic [31:0] mem_rd_addr;
    logic        mem_rd_valid = 1'b0;
    logic [31:0] mem_rd_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    int rd_cnt   = 0;
    bit finished = 1'b0;

    localparam logic [31:0] BASE_A = 32'h0001_3000;
    localparam logic [31:0] BASE_B = 32'h0002_7000;

    always #4 clk = ~clk;

    pt_walker u_pt_walker (
        .clk (clk), .rst_n (rst_n), .paging_en (paging_en),
        .base_wr_en (base_wr_en), .base_wr_data (base_wr_data),
        .req_valid (req_valid), .req_ready (req_ready), .req_addr (req_addr),
        .req_write (req_write), .req_user (req_user),
        .rsp_valid (rsp_valid), .rsp_paddr (rsp_paddr), .rsp_fault (rsp_fault),
        .rsp_fault_code (rsp_fault_code), .rsp_fault_addr (rsp_fault_addr),
        .mem_rd_en (mem_rd_en), .mem_rd_addr (mem_rd_addr),
        .mem_rd_valid (mem_rd_valid), .mem_rd_data (mem_rd_data)
    );

    // arithmetic memory image: every word derived from its address
    function automatic logic [31:0] mem_word(input logic [31:0] a);
        logic [19:0] f;
        logic [9:0]  i;
        logic [2:0]  c;
        f = a[31:12];
        i = a[11:2];
        c = i[2:0] ^ f[2:0] ^ i[5:3];
        return {f[9:0] ^ i, i, 9'b0, (~c[2] | c[0]), (c[0] | c[1]), (c != 3'd5)};
    endfunction

    always @(posedge clk) begin
        mem_rd_valid <= mem_rd_en;
        mem_rd_data  <= mem_rd_en ? mem_word(mem_rd_addr) : 32'h0;
        if (mem_rd_en) rd_cnt <= rd_cnt + 1;
    end

    // expected translation from the requirements
    task automatic model(input logic [31:0] la, input logic w, input logic u,
                         input logic [31:0] base, output logic [31:0] pa,
                         output logic [1:0] code, output int nrd, output bit cacheable);
        logic [31:0] pde, pte;
        logic        cw, cu;
        pde = mem_word({base[31:12], la[31:22], 2'b00});
        cacheable = 1'b0;
        pa = 32'h0;
        if (!pde[0]) begin
            code = 2'd1; nrd = 1; return;
        end
        pte = mem_word({pde[31:12], la[21:12], 2'b00});
        nrd = 2;
        if (!pte[0]) begin
            code = 2'd1; return;
        end
        cacheable = 1'b1;
        cw = pde[1] & pte[1];
        cu = pde[2] & pte[2];
        if (u && !cu)      code = 2'd3;
        else if (w && !cw) code = 2'd2;
        else begin
            code = 2'd0;
            pa = {pte[31:12], la[11:0]};
        end
    endtask

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_req(input logic [31:0] la, input logic w, input logic u,
                          output logic [31:0] pa, output logic [1:0] code,
                          output logic flt, output logic [31:0] fa,
                          output int nrd, output int lat);
        int start;
        while (!req_ready) @(negedge clk);
        start     = rd_cnt;
        req_valid = 1'b1;
        req_addr  = la;
        req_write = w;
        req_user  = u;
        @(posedge clk);
        lat = 0;
        do begin
            @(negedge clk);
            req_valid = 1'b0;
            lat++;
        end while (!rsp_valid && lat < 50);
        pa   = rsp_paddr;
        code = rsp_fault_code;
        flt  = rsp_fault;
        fa   = rsp_fault_addr;
        nrd  = rd_cnt - start;
    endtask

    task automatic write_root(input logic [31:0] v);
        while (!req_ready) @(negedge clk);
        base_wr_en   = 1'b1;
        base_wr_data = v;
        @(negedge clk);
        base_wr_en   = 1'b0;
    endtask

    // one request checked against the model
    task automatic run_one(input logic [31:0] la, input logic w, input logic u,
                           input logic [31:0] base, input bit expect_hit);
        logic [31:0] pa, fa, epa;
        logic [1:0]  code, ecode;
        logic        flt;
        int          nrd, lat, enrd;
        bit          cab;
        string       tag;
        model(la, w, u, base, epa, ecode, enrd, cab);
        do_req(la, w, u, pa, code, flt, fa, nrd, lat);
        case (ecode)
            2'd1: tag = "R4 absent";
            2'd2: tag = "R6 write";
            2'd3: tag = "R5 user";
            default: tag = "R3 translate";
        endcase
        chk(tag, {30'b0, code}, {30'b0, ecode});
        chk(tag, pa, epa);
        chk("R7 fault flag", {31'b0, flt}, {31'b0, (ecode != 2'd0)});
        chk("R7 fault addr", fa, la);
        if (expect_hit) begin
            chk("R8 hit reads", nrd, 0);
            chk("R8 hit latency", lat, 2);
        end else if (enrd == 1) begin
            chk("R4 walk stops at directory", nrd, 1);
        end else begin
            chk("R8 miss reads", nrd, enrd);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] pa, fa, epa;
        logic [1:0]  code, ecode;
        logic        flt;
        int          nrd, lat, enrd;
        bit          cab;
        logic [31:0] picks [5];
        int          np;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
        chk("R1 mem_rd_en", {31'b0, mem_rd_en}, 32'd0);

        // R1 root is 0 and cache empty: first paged request walks from root 0
        paging_en = 1'b1;
        run_one(32'h0040_1abc, 1'b0, 1'b0, 32'h0, 1'b0);

        // R2 passthrough sweep
        paging_en = 1'b0;
        for (int k = 0; k < 8; k++) begin
            logic [31:0] la;
            la = 32'h9e37_79b9 * (k + 1);
            do_req(la, k[0], k[1], pa, code, flt, fa, nrd, lat);
            chk("R2 paddr", pa, la);
            chk("R2 no fault", {31'b0, flt}, 32'd0);
            chk("R2 no reads", nrd, 0);
            chk("R2 latency", lat, 1);
        end

        // R3..R8 sweep under root A
        paging_en = 1'b1;
        write_root(BASE_A);
        for (int d = 0; d < 8; d++) begin
            for (int t = 0; t < 8; t++) begin
                logic [31:0] la;
                la = {d[9:0], t[9:0], 12'((d * t * 97 + 5) & 12'hfff)};
                model(la, 1'b0, 1'b0, BASE_A, epa, ecode, enrd, cab);
                for (int m = 0; m < 4; m++) begin
                    run_one(la, m[0], m[1], BASE_A, (m != 0) && cab);
                end
            end
        end

        // R9 round-robin replacement after a flush
        write_root(BASE_B);
        np = 0;
        for (int d = 0; d < 32 && np < 5; d++) begin
            for (int t = 0; t < 4 && np < 5; t++) begin
                logic [31:0] la;
                la = {d[9:0], t[9:0], 12'h123};
                model(la, 1'b0, 1'b0, BASE_B, epa, ecode, enrd, cab);
                if (cab) begin
                    picks[np] = la;
                    np++;
                end
            end
        end
        chk("R9 setup candidates", np, 5);
        for (int k = 0; k < 5; k++) run_one(picks[k], 1'b0, 1'b0, BASE_B, 1'b0);
        for (int k = 1; k < 5; k++) run_one(picks[k], 1'b0, 1'b1, BASE_B, 1'b1);
        run_one(picks[0], 1'b0, 1'b0, BASE_B, 1'b0);
        do_req(picks[0], 1'b0, 1'b0, pa, code, flt, fa, nrd, lat);
        chk("R9 refilled page hits", nrd, 0);

        // R10 root write flushes and re-roots
        do_req(picks[2], 1'b0, 1'b0, pa, code, flt, fa, nrd, lat);
        chk("R10 cached before flush", nrd, 0);
        write_root(BASE_A);
        model(picks[2], 1'b0, 1'b0, BASE_A, epa, ecode, enrd, cab);
        do_req(picks[2], 1'b0, 1'b0, pa, code, flt, fa, nrd, lat);
        chk("R10 walk after flush", nrd, enrd);
        chk("R10 new root code", {30'b0, code}, {30'b0, ecode});
        chk("R10 new root paddr", pa, epa);

        // R11 response pulse and ready only when idle
        @(negedge clk);
        chk("R11 rsp pulse", {31'b0, rsp_valid}, 32'd0);
        chk("R11 ready idle", {31'b0, req_ready}, 32'd1);

        finished = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
        $finish;
    end

endmodule